// File: doc/BRIEF.md
# Periodic Credit Rate Limiter Bank

A bank of token-bucket rate limiters that share one refill timer. Each entry holds a 32-bit credit kept in offset form: bit 31 set with all lower bits zero means zero credit, so the stored value is 2^31 plus the signed credit. While the bank is enabled, a shared countdown produces a refill tick once every `PERIOD_CYC` cycles. On each tick, every entry adds its own increment to its credit, and the result is capped at the upper bound.

A configuration port programs one entry per cycle from a byte rate. The increment is computed as (rate × PERIOD_US) / 8, with integer division. A rate of zero is replaced by `DEFAULT_RATE`, and a result below one becomes one. Programming an entry loads this increment and resets that entry's credit to zero. If the computed increment is larger than `MAX_INC`, the request is rejected. The entry is left untouched and an error flag is raised.

A consume port subtracts a transmitted byte count from one entry. An entry is eligible to send while its credit is non-negative. All credits, the per-entry eligibility and a bypass threshold are visible at the ports.

Top module: `rate_limiter_bank`

## Requirements
- R1: While `enable_i` is high, `tick_o` pulses for one cycle every `PERIOD_CYC` (default 125) cycles. The first pulse comes in the `PERIOD_CYC`-th cycle after enable rises.
- R2: An accepted configuration sets the entry increment to max(1, (r × PERIOD_US) / 8), with integer division. Here r is `cfg_rate_i`, or `DEFAULT_RATE` (1,000,000) when `cfg_rate_i` is 0.
- R3: A configuration whose increment would exceed `MAX_INC` (4,375,000) is rejected. `cfg_err_o` is high in the next cycle only, and that entry's credit and increment are left unchanged.
- R4: On a tick, an enabled entry adds its increment to its credit. The signed credit never rises above `UPPER_BOUND` (6,250,000), which is stored as 2^31 + 6,250,000.
- R5: An accepted configuration writes the entry's stored credit to 2^31 (zero credit). It takes precedence over a tick or a consume to the same entry in that cycle.
- R6: With `enable_i` high, `use_valid_i` subtracts `use_bytes_i` from entry `use_idx_i`. The credit may go negative. The stored value is floored at 0.
- R7: A tick and a consume to the same entry in the same cycle are both applied: credit + increment − bytes, then capped at the upper bound.
- R8: `eligible_o[i]` is high when `enable_i` is low, or when bit 31 of entry i's stored credit is set.
- R9: While `enable_i` is low, the timer is held reloaded, no ticks occur, and consumes leave credits unchanged.
- R10: `bypass_thr_o` equals `UPPER_BOUND` while `enable_i` is high, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Global limiter enable |
| cfg_valid_i | input | 1 | Configuration request |
| cfg_idx_i | input | IDX_W | Entry to configure |
| cfg_rate_i | input | RATE_W | Rate in bytes per microsecond unit; 0 selects the default |
| cfg_err_o | output | 1 | Previous-cycle configuration was rejected |
| use_valid_i | input | 1 | Consume request |
| use_idx_i | input | IDX_W | Entry to debit |
| use_bytes_i | input | BYTES_W | Byte count to debit |
| tick_o | output | 1 | Refill tick of the shared timer |
| eligible_o | output | NUM_ENT | Per-entry send eligibility |
| credit_o | output | NUM_ENT*CRD_W | Stored credits, entry 0 in the low word |
| bypass_thr_o | output | CRD_W | Bypass credit threshold |

## Verification
Four entries are programmed with a mid rate, a zero rate (default increment), a rate that floors to an increment of one, and the largest accepted rate. A rate one step above the largest accepted one is also sent, which separates the acceptance boundary from off-by-one errors. Consumes follow a fixed pseudo-random pattern, plus a consume forced into every tick cycle. This exposes lost updates when refill and debit coincide, and it drives some entries negative so eligibility toggles, while others reach the bound. A configuration paired with a consume to the same entry checks precedence. A disabled window with consumes applied shows that credits freeze and that the timer restarts with a full period afterwards.

// File: rtl/rl_pkg.sv
package rl_pkg;
  localparam int unsigned DEF_PERIOD_CYC = 125;
  localparam int unsigned DEF_PERIOD_US  = 5;
  localparam int unsigned DEF_UPPER      = 6250000;
  localparam int unsigned DEF_MAX_INC    = 4375000;
  localparam int unsigned DEF_RATE       = 1000000;

  // increment = max(1, rate_eff * period_us / 8)
  function automatic logic [63:0] rl_increment(input logic [63:0] rate,
                                               input logic [63:0] def_rate,
                                               input logic [63:0] period_us);
    logic [63:0] r, p;
    r = (rate == 64'd0) ? def_rate : rate;
    p = (r * period_us) >> 3;
    if (p == 64'd0) p = 64'd1;
    return p;
  endfunction
endpackage

// File: rtl/rl_period_timer.sv
module rl_period_timer #(
  parameter int unsigned PERIOD_CYC = 125,
  localparam int CNT_W = $clog2(PERIOD_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PERIOD_CYC);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= RELOAD;
    else if (!en_i)           cnt_q <= RELOAD;
    else if (cnt_q == LAST)   cnt_q <= RELOAD;
    else                      cnt_q <= cnt_q - LAST;
  end

  assign tick_o = en_i && (cnt_q == LAST);

  generate
    if (PERIOD_CYC > 1) begin : g_gap
      assert_tick_gap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == RELOAD));
endmodule

// File: rtl/rl_inc_calc.sv
module rl_inc_calc #(
  parameter int unsigned RATE_W       = 32,
  parameter int unsigned INC_W        = 32,
  parameter int unsigned PERIOD_US    = rl_pkg::DEF_PERIOD_US,
  parameter int unsigned DEFAULT_RATE = rl_pkg::DEF_RATE,
  parameter int unsigned MAX_INC      = rl_pkg::DEF_MAX_INC
) (
  input  logic [RATE_W-1:0] rate_i,
  output logic [INC_W-1:0]  inc_o,
  output logic              reject_o
);
  logic [63:0] full;

  always_comb begin
    full     = rl_pkg::rl_increment(64'(rate_i), 64'(DEFAULT_RATE), 64'(PERIOD_US));
    reject_o = full > 64'(MAX_INC);
    inc_o    = full[INC_W-1:0];
  end
endmodule

// File: rtl/rl_credit_slot.sv
module rl_credit_slot #(
  parameter int unsigned CRD_W       = 32,
  parameter int unsigned BYTES_W     = 16,
  parameter int unsigned UPPER_BOUND = rl_pkg::DEF_UPPER,
  localparam int SUM_W = CRD_W + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               tick_i,
  input  logic               cfg_we_i,
  input  logic [CRD_W-1:0]   cfg_inc_i,
  input  logic               use_we_i,
  input  logic [BYTES_W-1:0] use_bytes_i,
  output logic [CRD_W-1:0]   credit_o,
  output logic               eligible_o
);
  localparam logic [SUM_W-1:0] ZERO_PT = SUM_W'(1) << (CRD_W - 1);
  localparam logic [SUM_W-1:0] CEIL    = ZERO_PT + SUM_W'(UPPER_BOUND);

  logic [CRD_W-1:0] credit_q, inc_q;
  logic [SUM_W-1:0] sum, add_v, sub_v;
  logic [CRD_W-1:0] credit_d;

  always_comb begin
    add_v = tick_i ? {2'b00, inc_q} : '0;
    sub_v = use_we_i ? SUM_W'(use_bytes_i) : '0;
    sum   = {2'b00, credit_q} + add_v - sub_v;
    if (sum[SUM_W-1])     credit_d = '0;                 // borrow: floor
    else if (sum > CEIL)  credit_d = CEIL[CRD_W-1:0];
    else                  credit_d = sum[CRD_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      credit_q <= ZERO_PT[CRD_W-1:0];
      inc_q    <= '0;
    end else if (cfg_we_i) begin
      credit_q <= ZERO_PT[CRD_W-1:0];
      inc_q    <= cfg_inc_i;
    end else if (en_i) begin
      credit_q <= credit_d;
    end
  end

  assign credit_o   = credit_q;
  assign eligible_o = !en_i || credit_q[CRD_W-1];

  assert_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    credit_q <= CEIL[CRD_W-1:0]);
  assert_refill_up_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && tick_i && !use_we_i && !cfg_we_i |=> credit_q >= $past(credit_q));
  assert_cfg_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> credit_q == ZERO_PT[CRD_W-1:0]);
  assert_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !cfg_we_i |=> $stable(credit_q));
endmodule

// File: rtl/rate_limiter_bank.sv
module rate_limiter_bank #(
  parameter int unsigned NUM_ENT      = 4,
  parameter int unsigned RATE_W       = 32,
  parameter int unsigned BYTES_W      = 16,
  parameter int unsigned CRD_W        = 32,
  parameter int unsigned PERIOD_CYC   = rl_pkg::DEF_PERIOD_CYC,
  parameter int unsigned PERIOD_US    = rl_pkg::DEF_PERIOD_US,
  parameter int unsigned UPPER_BOUND  = rl_pkg::DEF_UPPER,
  parameter int unsigned MAX_INC      = rl_pkg::DEF_MAX_INC,
  parameter int unsigned DEFAULT_RATE = rl_pkg::DEF_RATE,
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       enable_i,
  input  logic                       cfg_valid_i,
  input  logic [IDX_W-1:0]           cfg_idx_i,
  input  logic [RATE_W-1:0]          cfg_rate_i,
  output logic                       cfg_err_o,
  input  logic                       use_valid_i,
  input  logic [IDX_W-1:0]           use_idx_i,
  input  logic [BYTES_W-1:0]         use_bytes_i,
  output logic                       tick_o,
  output logic [NUM_ENT-1:0]         eligible_o,
  output logic [NUM_ENT*CRD_W-1:0]   credit_o,
  output logic [CRD_W-1:0]           bypass_thr_o
);
  logic             tick;
  logic [CRD_W-1:0] new_inc;
  logic             reject;
  logic             err_q;

  rl_period_timer #(.PERIOD_CYC(PERIOD_CYC)) i_timer (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(enable_i), .tick_o(tick)
  );

  rl_inc_calc #(
    .RATE_W(RATE_W), .INC_W(CRD_W), .PERIOD_US(PERIOD_US),
    .DEFAULT_RATE(DEFAULT_RATE), .MAX_INC(MAX_INC)
  ) i_inc (
    .rate_i(cfg_rate_i), .inc_o(new_inc), .reject_o(reject)
  );

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    logic cfg_we, use_we;
    assign cfg_we = cfg_valid_i && !reject && (cfg_idx_i == IDX_W'(e));
    assign use_we = use_valid_i && (use_idx_i == IDX_W'(e));

    rl_credit_slot #(
      .CRD_W(CRD_W), .BYTES_W(BYTES_W), .UPPER_BOUND(UPPER_BOUND)
    ) i_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (enable_i),
      .tick_i     (tick),
      .cfg_we_i   (cfg_we),
      .cfg_inc_i  (new_inc),
      .use_we_i   (use_we),
      .use_bytes_i(use_bytes_i),
      .credit_o   (credit_o[e*CRD_W +: CRD_W]),
      .eligible_o (eligible_o[e])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= cfg_valid_i && reject;
  end

  assign cfg_err_o    = err_q;
  assign tick_o       = tick;
  assign bypass_thr_o = enable_i ? CRD_W'(UPPER_BOUND) : '0;

  assert_reject_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_i && reject |=> cfg_err_o);
  assert_no_err_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_valid_i |=> !cfg_err_o);
  assert_inc_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_i && !reject |-> (new_inc >= CRD_W'(1)) && (new_inc <= CRD_W'(MAX_INC)));
  assert_elig_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> &eligible_o);
endmodule

// File: tb/test_rate_limiter_bank.sv
module test_rate_limiter_bank;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 4;
  localparam int CW  = 32;
  localparam longint UB    = 6250000;
  localparam longint MAXI  = 4375000;
  localparam longint ZPT   = 64'h8000_0000;
  localparam int     PER   = 125;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic cfg_v = 1'b0;
  logic [1:0] cfg_i = '0;
  logic [31:0] cfg_r = '0;
  logic use_v = 1'b0;
  logic [1:0] use_i = '0;
  logic [15:0] use_b = '0;
  logic cfg_err, tick;
  logic [N-1:0] elig;
  logic [N*CW-1:0] crd;
  logic [CW-1:0] byp;

  always #(CLK_PERIOD/2) clk = ~clk;

  rate_limiter_bank i_rate_limiter_bank (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en),
    .cfg_valid_i(cfg_v), .cfg_idx_i(cfg_i), .cfg_rate_i(cfg_r), .cfg_err_o(cfg_err),
    .use_valid_i(use_v), .use_idx_i(use_i), .use_bytes_i(use_b),
    .tick_o(tick), .eligible_o(elig), .credit_o(crd), .bypass_thr_o(byp)
  );

  // behavioural reference
  longint m_cr[N];
  longint m_inc[N];
  int     m_cnt = PER;
  bit     m_err = 0;
  int     n_cmp = 0;
  int     n_bad = 0;
  bit     done  = 0;
  string  ctx   = "R0";

  function automatic longint inc_of(longint r);
    longint x;
    x = ((r == 0 ? 1000000 : r) * 5) / 8;
    return (x < 1) ? 1 : x;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_cr[e]) begin m_cr[e] = 0; m_inc[e] = 0; end
      m_cnt = PER; m_err = 0;
    end else begin
      bit t, hit;
      longint ni;
      t = en && (m_cnt == 1);
      if (!en || m_cnt == 1) m_cnt = PER; else m_cnt--;
      hit = 0; m_err = 0; ni = 0;
      if (cfg_v) begin
        ni = inc_of(longint'(cfg_r));
        if (ni > MAXI) m_err = 1; else hit = 1;
      end
      for (int e = 0; e < N; e++) begin
        if (hit && cfg_i == e) begin
          m_cr[e] = 0; m_inc[e] = ni;
        end else if (en) begin
          if (t) m_cr[e] += m_inc[e];
          if (use_v && use_i == e) m_cr[e] -= longint'(use_b);
          if (m_cr[e] > UB) m_cr[e] = UB;
          if (m_cr[e] < -ZPT) m_cr[e] = -ZPT;
        end
      end
    end
  end

  task automatic cmp(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s (%s) t=%0t actual=%0d expected=%0d", tag, ctx, $time, act, exp);
    end
  endtask

  task automatic check_all();
    cmp("R1", longint'(tick), longint'(en && m_cnt == 1));
    cmp("R10", longint'(byp), en ? UB : 0);
    cmp("R3", longint'(cfg_err), longint'(m_err));
    for (int e = 0; e < N; e++) begin
      cmp("R6", longint'(crd[e*CW +: CW]), m_cr[e] + ZPT);
      cmp("R8", longint'(elig[e]), longint'(!en || m_cr[e] >= 0));
    end
  endtask

  task automatic step();
    @(negedge clk);
    check_all();
  endtask

  task automatic drive(bit cv, int ci, longint cr, bit uv, int ui, int ub);
    cfg_v = cv; cfg_i = 2'(ci); cfg_r = 32'(cr);
    use_v = uv; use_i = 2'(ui); use_b = 16'(ub);
    step();
  endtask

  task automatic run(int cycles);
    for (int c = 0; c < cycles; c++) begin
      bit uv;
      uv = (c % 7 == 3) || (en && m_cnt == 1);   // R7: force a debit on each tick
      drive(0, 0, 0, uv, (c / 7) % N, (c * 37) % 4000 + 1);
    end
  endtask

  initial begin
    ctx = "reset";
    repeat (3) step();
    rst_n = 1'b1;
    step();
    en = 1'b1;
    ctx = "R2";
    drive(1, 0, 8000, 0, 0, 0);       // inc 5000
    drive(1, 1, 0, 0, 0, 0);          // default rate -> 625000
    drive(1, 2, 1, 0, 0, 0);          // floor -> 1
    drive(1, 3, 7000001, 0, 0, 0);    // 4375000, accepted
    ctx = "R3";
    drive(1, 3, 7000002, 0, 0, 0);    // 4375001, rejected
    drive(0, 0, 0, 0, 0, 0);
    ctx = "R4 R7";
    run(1600);
    ctx = "R5";
    drive(1, 0, 16000, 1, 0, 500);    // cfg beats consume on same entry
    drive(0, 0, 0, 0, 0, 0);
    ctx = "R9";
    en = 1'b0;
    run(300);
    ctx = "R1 R6";
    en = 1'b1;
    run(700);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule